// File: doc/BRIEF.md
# TLB Invalidation Controller

This block lets software remove stale translations from a small translation lookaside buffer (TLB) that is shared by two translation units. Software programs it over a simple 32-bit register bus. A select mask chooses which units an operation touches. A command register starts one of two operations:

- A flush of every entry at once.
- A scan that drops only those entries whose virtual page falls inside an inclusive address window. Software programs the window as a start address and a last address (start + size − 1).

When the scan ends, a completion flag goes high. Software polls this flag and clears it by writing zero.

The TLB is modelled inside the block as one tag bank per unit. Each bank holds a valid bit and a virtual page number for every entry. A fill port loads the banks, standing in for the page-table walker. The packed valid bits are brought out so that the state of the TLB can be observed. A full flush takes effect at once and is accepted even while a scan is running. Software that times out on the completion flag can therefore always fall back to a full flush.

Top module: `tlbi_ctrl`

## Requirements
- R1: After reset, every valid bit is 0, and every register reads 0: select, window start, window end, completion and command status.
- R2: Register map:
  - The select register at byte offset 0x038 keeps bits [NUM_UNITS-1:0] of the last value written, and its other bits read 0.
  - The start register (0x024) and the end register (0x028) read back the full last value written.
  - Any offset other than 0x020, 0x024, 0x028, 0x038 and 0x12C reads 0.
- R3: A write to the command register (0x020) with bit 1 set clears, at that clock edge, every valid bit of each unit u whose select bit u is 1. Units whose select bit is 0 keep their entries.
- R4: A command write with bit 1 clear and bit 0 set, made while no scan runs, starts a scan. The scan clears the valid bit of every entry in the selected units whose page number (address >> 12) lies in [start >> 12, end >> 12], both ends included. All other entries are kept.
- R5: A scan visits one entry per clock, so it lasts exactly ENTRIES cycles. While it runs, bit 0 of the command register reads 1. The edge that ends the scan also sets the completion register (0x12C), which then reads 1.
- R6: Writing 0 to the completion register clears it. Writing a nonzero value leaves it unchanged. Starting a new scan clears it.
- R7: A scan command written while a scan runs is ignored: the running scan neither restarts nor clears the completion flag. A scan uses the select mask and window captured when it started, so later writes to those registers do not change it.
- R8: A full flush is accepted while a scan runs. It never changes the completion flag, and the running scan still completes normally.
- R9: A fill writes the page number and sets the valid bit of the addressed entry. If a flush or a scan clears the same entry at the same edge, the clear wins.
- R10: A scan whose start page is above its end page clears nothing, but still runs for ENTRIES cycles and sets the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset for read and write |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for bus_addr (combinational) |
| fill_en | input | 1 | Load one TLB entry |
| fill_unit | input | UNIT_W | Unit whose bank is loaded |
| fill_idx | input | IDX_W | Entry index loaded |
| fill_vpn | input | DATA_W-PAGE_SHIFT | Virtual page number stored |
| tlb_valid | output | NUM_UNITS*ENTRIES | Valid bits, unit u entry i at bit u*ENTRIES+i |

## Verification
Two functions can act in the same cycle:

- **Full flush during a scan.** A full flush can arrive while a scan is clearing entries of the same bank. The bench starts a narrow scan on unit 0, switches the select mask to unit 1, and issues a full flush a few cycles into the scan. It then checks three things: unit 1 is empty at once, the completion flag is still 0 and busy still reads 1, and the scan later finishes with its own entries removed.
- **Fill against flush.** A fill can land on the same edge as a flush of its unit. The bench drives both in one cycle and expects the filled entry to end invalid.

// File: rtl/tlbi_pkg.sv
`timescale 1ns/1ps
package tlbi_pkg;

    // Register byte offsets decoded by software
    localparam int unsigned OFF_CMD  = 'h020;
    localparam int unsigned OFF_LO   = 'h024;
    localparam int unsigned OFF_HI   = 'h028;
    localparam int unsigned OFF_SEL  = 'h038;
    localparam int unsigned OFF_DONE = 'h12C;

    // Command register bit positions
    localparam int unsigned CMD_RANGE_BIT = 0;
    localparam int unsigned CMD_FULL_BIT  = 1;
    localparam int unsigned STAT_BUSY_BIT = 0;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_FULL  = 2'd1,
        OP_RANGE = 2'd2
    } op_e;

endpackage

// File: rtl/tlbi_regs.sv
`timescale 1ns/1ps
module tlbi_regs
    import tlbi_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_UNITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 scan_busy,
    input  logic                 scan_done_set,
    output logic [NUM_UNITS-1:0] sel_q,
    output logic [DATA_W-1:0]    lo_q,
    output logic [DATA_W-1:0]    hi_q,
    output logic                 done_q,
    output op_e                  cmd_op
);

    typedef struct packed {
        logic [NUM_UNITS-1:0] sel;
        logic [DATA_W-1:0]    lo;
        logic [DATA_W-1:0]    hi;
        logic                 done;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        cmd_op = OP_NONE;
        if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_SEL)) begin
                r_d.sel = bus_wdata[NUM_UNITS-1:0];
            end else if (bus_addr == ADDR_W'(OFF_LO)) begin
                r_d.lo = bus_wdata;
            end else if (bus_addr == ADDR_W'(OFF_HI)) begin
                r_d.hi = bus_wdata;
            end else if (bus_addr == ADDR_W'(OFF_DONE)) begin
                if (bus_wdata == '0) begin
                    r_d.done = 1'b0;
                end
            end else if (bus_addr == ADDR_W'(OFF_CMD)) begin
                // full flush has priority and is never blocked by a scan
                if (bus_wdata[CMD_FULL_BIT]) begin
                    cmd_op = OP_FULL;
                end else if (bus_wdata[CMD_RANGE_BIT] && !scan_busy) begin
                    cmd_op   = OP_RANGE;
                    r_d.done = 1'b0;
                end
            end
        end
        // completion of a scan wins over a clearing write in the same cycle
        if (scan_done_set) begin
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_q  = r_q.sel;
    assign lo_q   = r_q.lo;
    assign hi_q   = r_q.hi;
    assign done_q = r_q.done;

endmodule

// File: rtl/tlbi_scan.sv
`timescale 1ns/1ps
module tlbi_scan #(
    parameter int DATA_W     = 32,
    parameter int NUM_UNITS  = 2,
    parameter int ENTRIES    = 16,
    parameter int PAGE_SHIFT = 12,
    localparam int VPN_W     = DATA_W - PAGE_SHIFT,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [NUM_UNITS-1:0]            sel_in,
    input  logic [DATA_W-1:0]               lo_addr,
    input  logic [DATA_W-1:0]               hi_addr,
    input  logic [NUM_UNITS-1:0][VPN_W-1:0] rd_vpn,
    input  logic [NUM_UNITS-1:0]            rd_vld,
    output logic                            busy,
    output logic [IDX_W-1:0]                idx,
    output logic [NUM_UNITS-1:0]            clr_en,
    output logic                            done_set
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic                 busy;
        logic [IDX_W-1:0]     idx;
        logic [NUM_UNITS-1:0] sel;
        logic [VPN_W-1:0]     lo;
        logic [VPN_W-1:0]     hi;
    } scan_t;

    scan_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        clr_en   = '0;
        done_set = 1'b0;
        if (s_q.busy) begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                clr_en[u] = s_q.sel[u] && rd_vld[u]
                         && (rd_vpn[u] >= s_q.lo) && (rd_vpn[u] <= s_q.hi);
            end
            if (s_q.idx == LAST) begin
                s_d.busy = 1'b0;
                s_d.idx  = '0;
                done_set = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end else if (start) begin
            // snapshot the operands so later register writes do not disturb the scan
            s_d.busy = 1'b1;
            s_d.idx  = '0;
            s_d.sel  = sel_in;
            s_d.lo   = VPN_W'(lo_addr >> PAGE_SHIFT);
            s_d.hi   = VPN_W'(hi_addr >> PAGE_SHIFT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign idx  = s_q.idx;

endmodule

// File: rtl/tlbi_tag_bank.sv
`timescale 1ns/1ps
module tlbi_tag_bank #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [VPN_W-1:0]   rd_vpn,
    output logic               rd_vld,
    output logic [ENTRIES-1:0] vld_bits
);

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (fill_en) begin
            b_d.vld[fill_idx] = 1'b1;
            b_d.vpn[fill_idx] = fill_vpn;
        end
        // invalidation is applied after the fill so that it wins
        if (clr_en) begin
            b_d.vld[clr_idx] = 1'b0;
        end
        if (flush) begin
            b_d.vld = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_vpn   = b_q.vpn[rd_idx];
    assign rd_vld   = b_q.vld[rd_idx];
    assign vld_bits = b_q.vld;

endmodule

// File: rtl/tlbi_ctrl.sv
`timescale 1ns/1ps
module tlbi_ctrl
    import tlbi_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int NUM_UNITS  = 2,
    parameter int ENTRIES    = 16,
    parameter int PAGE_SHIFT = 12,
    localparam int VPN_W     = DATA_W - PAGE_SHIFT,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic                           fill_en,
    input  logic [UNIT_W-1:0]              fill_unit,
    input  logic [IDX_W-1:0]               fill_idx,
    input  logic [VPN_W-1:0]               fill_vpn,
    output logic [NUM_UNITS*ENTRIES-1:0]   tlb_valid
);

    logic [NUM_UNITS-1:0]            sel_q;
    logic [DATA_W-1:0]               lo_q;
    logic [DATA_W-1:0]               hi_q;
    logic                            done_q;
    op_e                             cmd_op;
    logic                            scan_busy;
    logic [IDX_W-1:0]                scan_idx;
    logic                            scan_done_set;
    logic [NUM_UNITS-1:0]            clr_en;
    logic [NUM_UNITS-1:0][VPN_W-1:0] rd_vpn;
    logic [NUM_UNITS-1:0]            rd_vld;

    tlbi_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_UNITS (NUM_UNITS)
    ) i_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .scan_busy     (scan_busy),
        .scan_done_set (scan_done_set),
        .sel_q         (sel_q),
        .lo_q          (lo_q),
        .hi_q          (hi_q),
        .done_q        (done_q),
        .cmd_op        (cmd_op)
    );

    tlbi_scan #(
        .DATA_W     (DATA_W),
        .NUM_UNITS  (NUM_UNITS),
        .ENTRIES    (ENTRIES),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) i_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_op == OP_RANGE),
        .sel_in   (sel_q),
        .lo_addr  (lo_q),
        .hi_addr  (hi_q),
        .rd_vpn   (rd_vpn),
        .rd_vld   (rd_vld),
        .busy     (scan_busy),
        .idx      (scan_idx),
        .clr_en   (clr_en),
        .done_set (scan_done_set)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic unit_fill;
        logic unit_flush;
        assign unit_fill  = fill_en && (fill_unit == UNIT_W'(u));
        assign unit_flush = (cmd_op == OP_FULL) && sel_q[u];

        tlbi_tag_bank #(
            .ENTRIES (ENTRIES),
            .VPN_W   (VPN_W)
        ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (unit_flush),
            .clr_en   (clr_en[u]),
            .clr_idx  (scan_idx),
            .fill_en  (unit_fill),
            .fill_idx (fill_idx),
            .fill_vpn (fill_vpn),
            .rd_idx   (scan_idx),
            .rd_vpn   (rd_vpn[u]),
            .rd_vld   (rd_vld[u]),
            .vld_bits (tlb_valid[u*ENTRIES +: ENTRIES])
        );
    end

    // read data mux; unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CMD)) begin
            bus_rdata[STAT_BUSY_BIT] = scan_busy;
        end else if (bus_addr == ADDR_W'(OFF_SEL)) begin
            bus_rdata[NUM_UNITS-1:0] = sel_q;
        end else if (bus_addr == ADDR_W'(OFF_LO)) begin
            bus_rdata = lo_q;
        end else if (bus_addr == ADDR_W'(OFF_HI)) begin
            bus_rdata = hi_q;
        end else if (bus_addr == ADDR_W'(OFF_DONE)) begin
            bus_rdata[0] = done_q;
        end
    end

endmodule

// File: rtl/tlbi_ctrl_chk.sv
`timescale 1ns/1ps
module tlbi_ctrl_chk
    import tlbi_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_UNITS = 2,
    parameter int ENTRIES   = 16,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_wr,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic [NUM_UNITS-1:0]         sel_q,
    input logic                         done_q,
    input op_e                          cmd_op,
    input logic                         scan_busy,
    input logic [IDX_W-1:0]             scan_idx,
    input logic [NUM_UNITS*ENTRIES-1:0] tlb_valid
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic scan_last;
    assign scan_last = scan_busy && (scan_idx == LAST);

    // R5
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_busy) |-> done_q);

    // R5
    scan_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_busy) |-> ($past(scan_idx) == LAST));

    // R7
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_busy && !scan_last) |=> (scan_busy && (scan_idx == IDX_W'($past(scan_idx) + 1'b1))));

    // R8
    full_keeps_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_op == OP_FULL) && !scan_last) |=> $stable(done_q));

    // R6
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(OFF_DONE)) && (bus_wdata == '0) && !scan_last) |=> !done_q);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit_chk
        // R3
        full_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmd_op == OP_FULL) && sel_q[u]) |=> (tlb_valid[u*ENTRIES +: ENTRIES] == '0));
    end

endmodule

bind tlbi_ctrl tlbi_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_UNITS (NUM_UNITS),
    .ENTRIES   (ENTRIES)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sel_q     (sel_q),
    .done_q    (done_q),
    .cmd_op    (cmd_op),
    .scan_busy (scan_busy),
    .scan_idx  (scan_idx),
    .tlb_valid (tlb_valid)
);

// File: tb/test_tlbi_ctrl.sv
`timescale 1ns/1ps
module test_tlbi_ctrl;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NU = 2;
    localparam int NE = 16;
    localparam int PS = 12;
    localparam int VW = DW - PS;
    localparam int IW = $clog2(NE);

    localparam logic [AW-1:0] A_CMD  = 12'h020;
    localparam logic [AW-1:0] A_LO   = 12'h024;
    localparam logic [AW-1:0] A_HI   = 12'h028;
    localparam logic [AW-1:0] A_SEL  = 12'h038;
    localparam logic [AW-1:0] A_DONE = 12'h12C;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr;
    logic [AW-1:0]     bus_addr;
    logic [DW-1:0]     bus_wdata;
    logic [DW-1:0]     bus_rdata;
    logic              fill_en;
    logic [0:0]        fill_unit;
    logic [IW-1:0]     fill_idx;
    logic [VW-1:0]     fill_vpn;
    logic [NU*NE-1:0]  tlb_valid;

    always #2 clk = ~clk;   // 4 ns period

    tlbi_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .NUM_UNITS(NU), .ENTRIES(NE), .PAGE_SHIFT(PS)
    ) i_tlbi_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fill_en(fill_en),
        .fill_unit(fill_unit), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
        .tlb_valid(tlb_valid)
    );

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        bit            is_vld;
        logic [DW-1:0] exp;
        string         tag;
    } sb_item_t;

    sb_item_t    sb_q[$];
    event        mon_ev;
    logic [NU*NE-1:0] m_vld;
    int unsigned m_vpn [NU][NE];

    function automatic void report(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endfunction

    // monitor: pops expected items and compares against the live outputs
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [DW-1:0] act;
                it  = sb_q.pop_front();
                act = it.is_vld ? DW'(tlb_valid) : bus_rdata;
                report(act === it.exp, it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic exp_reg(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_addr = a;
        #1;
        it.is_vld = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
    endtask

    task automatic exp_vld(input string tag);
        sb_item_t it;
        @(negedge clk);
        #1;
        it.is_vld = 1'b1; it.exp = DW'(m_vld); it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
    endtask

    task automatic fill_all();
        for (int u = 0; u < NU; u++) begin
            for (int i = 0; i < NE; i++) begin
                @(negedge clk);
                fill_en   = 1'b1;
                fill_unit = 1'(u);
                fill_idx  = IW'(i);
                m_vpn[u][i] = (u == 0) ? ('h100 + i) : ('h100 + 2 * i);
                fill_vpn  = VW'(m_vpn[u][i]);
                m_vld[u*NE + i] = 1'b1;
            end
        end
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            bus_addr = A_DONE;
            #1;
            cyc++;
        end while (!bus_rdata[0] && cyc < 1000);
    endtask

    function automatic void model_range(input logic [NU-1:0] sel, input int unsigned lo, input int unsigned hi);
        for (int u = 0; u < NU; u++)
            for (int i = 0; i < NE; i++)
                if (sel[u] && m_vpn[u][i] >= (lo >> PS) && m_vpn[u][i] <= (hi >> PS))
                    m_vld[u*NE + i] = 1'b0;
    endfunction

    function automatic void model_full(input logic [NU-1:0] sel);
        for (int u = 0; u < NU; u++)
            if (sel[u]) m_vld[u*NE +: NE] = '0;
    endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        report(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        fill_en = 1'b0; fill_unit = '0; fill_idx = '0; fill_vpn = '0;
        m_vld = '0;
        for (int u = 0; u < NU; u++) for (int i = 0; i < NE; i++) m_vpn[u][i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_vld("R1 valid after reset");
        exp_reg(A_SEL, 0, "R1 select");
        exp_reg(A_LO, 0, "R1 start");
        exp_reg(A_HI, 0, "R1 end");
        exp_reg(A_DONE, 0, "R1 done");
        exp_reg(A_CMD, 0, "R1 busy");

        // R2 register readback and unmapped offsets
        wr(A_SEL, 32'h3);
        exp_reg(A_SEL, 32'h3, "R2 select");
        wr(A_SEL, 32'hFFFF_FFFD);
        exp_reg(A_SEL, 32'h1, "R2 select masked");
        wr(A_LO, 32'h1234_5000);
        exp_reg(A_LO, 32'h1234_5000, "R2 start");
        wr(A_HI, 32'hCAFE_F00D);
        exp_reg(A_HI, 32'hCAFE_F00D, "R2 end");
        wr(12'h030, 32'hFFFF_FFFF);
        exp_reg(12'h030, 0, "R2 unmapped 0x030");
        exp_reg(12'h100, 0, "R2 unmapped 0x100");

        // R9 fill loads entries
        fill_all();
        exp_vld("R9 fill sets valid");

        // R4 / R5 range on unit 0, pages 0x105..0x108
        wr(A_SEL, 32'h1);
        wr(A_LO, 32'h0010_5000);
        wr(A_HI, 32'h0010_8FFF);
        wr(A_CMD, 32'h1);
        wait_done(cyc);
        report(cyc == NE, "R5 scan length", DW'(cyc), DW'(NE));
        model_range(2'b01, 32'h0010_5000, 32'h0010_8FFF);
        exp_vld("R4 inclusive range unit0");
        exp_reg(A_DONE, 1, "R5 done set");
        exp_reg(A_CMD, 0, "R5 busy low after scan");

        // R6 completion flag clearing
        wr(A_DONE, 32'h5);
        exp_reg(A_DONE, 1, "R6 nonzero write keeps done");
        wr(A_SEL, 32'h0);
        wr(A_CMD, 32'h1);
        exp_reg(A_DONE, 0, "R6 new scan clears done");
        wait_done(cyc);
        wr(A_DONE, 32'h0);
        exp_reg(A_DONE, 0, "R6 zero write clears done");

        // R7 command during scan ignored; operands snapshotted
        wr(A_SEL, 32'h3);
        wr(A_LO, 32'h0010_A000);
        wr(A_HI, 32'h0010_AFFF);
        wr(A_CMD, 32'h1);
        exp_reg(A_CMD, 1, "R5 busy during scan");
        wr(A_LO, 32'h0010_0000);
        wr(A_HI, 32'h001F_FFFF);
        wr(A_SEL, 32'h0);
        wr(A_CMD, 32'h1);
        wait_done(cyc);
        model_range(2'b11, 32'h0010_A000, 32'h0010_AFFF);
        exp_vld("R7 snapshot window used");
        exp_reg(A_DONE, 1, "R7 ignored command kept done");
        wr(A_DONE, 32'h0);

        // R3 full flush of unit 0 only
        fill_all();
        wr(A_SEL, 32'h1);
        wr(A_CMD, 32'h2);
        model_full(2'b01);
        exp_vld("R3 full flush selected unit");
        exp_reg(A_DONE, 0, "R8 full flush leaves done");

        // R8 full flush during a running scan
        fill_all();
        wr(A_SEL, 32'h1);
        wr(A_LO, 32'h0010_0000);
        wr(A_HI, 32'h0010_1FFF);
        wr(A_CMD, 32'h1);
        wr(A_SEL, 32'h2);
        wr(A_CMD, 32'h2);
        model_range(2'b01, 32'h0010_0000, 32'h0010_1FFF);
        model_full(2'b10);
        exp_vld("R8 flush during scan");
        exp_reg(A_DONE, 0, "R8 done unchanged mid scan");
        exp_reg(A_CMD, 1, "R8 scan still busy");
        wait_done(cyc);
        exp_vld("R8 scan completed after flush");
        wr(A_SEL, 32'h3);
        wr(A_CMD, 32'h2);
        model_full(2'b11);
        exp_reg(A_DONE, 1, "R8 flush keeps done set");
        exp_vld("R3 full flush both units");
        wr(A_DONE, 32'h0);

        // R9 fill and flush on the same edge
        fill_all();
        wr(A_SEL, 32'h1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_CMD; bus_wdata = 32'h2;
        fill_en = 1'b1; fill_unit = 1'b0; fill_idx = IW'(3); fill_vpn = VW'('h777);
        @(negedge clk);
        bus_wr = 1'b0; fill_en = 1'b0;
        m_vpn[0][3] = 'h777;
        model_full(2'b01);
        exp_vld("R9 clear wins over fill");

        // R10 inverted window
        fill_all();
        wr(A_SEL, 32'h3);
        wr(A_LO, 32'h0011_0000);
        wr(A_HI, 32'h0010_0000);
        wr(A_CMD, 32'h1);
        wait_done(cyc);
        report(cyc == NE, "R10 scan length", DW'(cyc), DW'(NE));
        exp_vld("R10 nothing cleared");
        exp_reg(A_DONE, 1, "R10 done set");

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule